// File: doc/BRIEF.md
# Selectable Clock Divider Output Bank

This block turns one fast source clock into nine divided clock outputs in four groups. Group A has one output, group B has one, group C has two and group D has five. The source comes from a 2:1 clock selector. In normal operation it is the internal oscillator clock. In bypass operation it is a reference clock, which is itself either a test clock or a clock derived from a differential input. Each group has a one-bit ratio select of its own. Every ratio is even, so every output has a 50% duty cycle.

All dividers are taps of one shared down-counter, so outputs of different ratios stay phase aligned. After reset, every output rises on the first source edge. One active-high control input both clears the counter and puts all nine outputs into high impedance. A new ratio select pattern is loaded only when the counter wraps, which keeps runt pulses off the outputs. Users feed one output back to an external phase comparator and drive the rest to their loads.

Top module: `clk_div_bank`

## Requirements
- R1: Group A (`out_a`) divides the source by 2 when `ratio_sel[0]` is 0 and by 4 when it is 1.
- R2: Groups B, C and D divide the source by 4 when their select bit is 0 and by 8 when it is 1. The select bits are `ratio_sel[1]` for B, `ratio_sel[2]` for C and `ratio_sel[3]` for D.
- R3: All bits of `out_c` carry the same level at all times, and so do all bits of `out_d`.
- R4: While `mr_oe` is high, all nine outputs are high impedance and the divider state is cleared. While it is low, the outputs are driven.
- R5: After `mr_oe` falls, every output is low until the first source rising edge. On that edge every output rises, whatever its ratio.
- R6: Each output is high for exactly half of its period, measured in source edges.
- R7: With `pll_on` low, the source is `test_clk` when `ref_sel` is 1 and `diff_clk` when `ref_sel` is 0.
- R8: With `pll_on` high, the source is `osc_clk`, whatever the value of `ref_sel`.
- R9: `ratio_sel` is sampled only on the source edges numbered 1, 9, 17 and so on after reset release, which are the edges where the counter wraps. A change made between those edges has no effect on any output until the next such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, the source in normal operation |
| test_clk | input | 1 | Test reference clock |
| diff_clk | input | 1 | Reference clock derived from the differential input |
| ref_sel | input | 1 | Reference choice: 1 selects test_clk, 0 selects diff_clk |
| pll_on | input | 1 | 1 selects the oscillator clock, 0 selects bypass to the reference |
| mr_oe | input | 1 | Active-high clear and output disable |
| ratio_sel | input | 4 | Per-group ratio selects: bit 0 for A, bit 1 for B, bit 2 for C, bit 3 for D |
| out_a | output | 1 | Group A clock |
| out_b | output | 1 | Group B clock |
| out_c | output | C_OUTS (2) | Group C clocks |
| out_d | output | D_OUTS (5) | Group D clocks |

## Verification
The hardest case to reach from the ports is a select change that lands partway through a counter cycle. A block that applied the change at once would still look correct as soon as the change settled. So the bench steps through all sixteen select patterns while the bank keeps running, and each new pattern arrives several source edges away from a wrap. Its per-edge model checks that the old ratio continues up to the wrap edge. The bench also places pull-ups on every output net. These let it tell an undriven output (it reads high during reset) from a driven-low output (it reads low just after release). It repeats the reset and release sequence once for each of the three clock sources.

// File: rtl/clk_div_bank_pkg.sv
`timescale 1ns/1ps
package clk_div_bank_pkg;

  // Shared down-counter width: bit 0 is /2, bit 1 is /4, bit 2 is /8
  localparam int CNT_W      = 3;
  localparam int NUM_GROUPS = 4;

  typedef enum logic [1:0] {
    GRP_A = 2'd0,
    GRP_B = 2'd1,
    GRP_C = 2'd2,
    GRP_D = 2'd3
  } grp_e;

  // Counter bit that serves as the divided clock for a group and its select
  function automatic logic [1:0] tap_index(grp_e g, logic slow);
    if (g == GRP_A) return slow ? 2'd1 : 2'd0;
    return slow ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/src_clk_mux.sv
`timescale 1ns/1ps
module src_clk_mux (
  input  logic osc_clk,
  input  logic test_clk,
  input  logic diff_clk,
  input  logic ref_sel,
  input  logic pll_on,
  output logic src_clk
);

  logic ref_clk;

  // Reference path: test clock or differential-derived clock
  assign ref_clk = ref_sel ? test_clk : diff_clk;

  // Bypass places the reference directly on the divider clock
  assign src_clk = pll_on ? osc_clk : ref_clk;

endmodule

// File: rtl/phase_counter.sv
`timescale 1ns/1ps
module phase_counter
  import clk_div_bank_pkg::*;
#(
  parameter int NSEL = NUM_GROUPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSEL-1:0]  sel_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [NSEL-1:0]  sel_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [NSEL-1:0]  sel_q;

  // All taps are zero at the wrap point, so every output is low there
  assign wrap_o = (cnt_q == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (wrap_o) sel_q <= sel_in;
    end
  end

  assign cnt_o = cnt_q;
  assign sel_o = sel_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt_q == $past(cnt_q) - 1'b1) else $error("count skipped"); // R6

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wrap_o |=> $stable(sel_q)) else $error("select moved off wrap"); // R9

endmodule

// File: rtl/out_group.sv
`timescale 1ns/1ps
module out_group
  import clk_div_bank_pkg::*;
#(
  parameter grp_e GRP   = GRP_B,
  parameter int   WIDTH = 1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             sel_bit,
  input  logic             drive_en,
  output logic             tap_o,
  output logic [WIDTH-1:0] q
);

  logic [1:0] idx;

  assign idx   = tap_index(GRP, sel_bit);
  assign tap_o = cnt[idx];

  // Every member of the group is a copy of the same tap
  for (genvar i = 0; i < WIDTH; i++) begin : g_member
    assign q[i] = drive_en ? tap_o : 1'bz;
  end

endmodule

// File: rtl/clk_div_bank.sv
`timescale 1ns/1ps
module clk_div_bank
  import clk_div_bank_pkg::*;
#(
  parameter int C_OUTS = 2,
  parameter int D_OUTS = 5
) (
  input  logic              osc_clk,
  input  logic              test_clk,
  input  logic              diff_clk,
  input  logic              ref_sel,
  input  logic              pll_on,
  input  logic              mr_oe,
  input  logic [3:0]        ratio_sel,
  output logic              out_a,
  output logic              out_b,
  output logic [C_OUTS-1:0] out_c,
  output logic [D_OUTS-1:0] out_d
);

  logic             src_clk;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       sel_act;
  logic             at_wrap;
  logic             drive_en;
  logic             tap_a, tap_b, tap_c, tap_d;

  assign drive_en = ~mr_oe;

  src_clk_mux u_mux (
    .osc_clk  (osc_clk),
    .test_clk (test_clk),
    .diff_clk (diff_clk),
    .ref_sel  (ref_sel),
    .pll_on   (pll_on),
    .src_clk  (src_clk)
  );

  phase_counter #(.NSEL(4)) u_cnt (
    .clk    (src_clk),
    .rst    (mr_oe),
    .sel_in (ratio_sel),
    .cnt_o  (cnt),
    .sel_o  (sel_act),
    .wrap_o (at_wrap)
  );

  out_group #(.GRP(GRP_A), .WIDTH(1)) u_grp_a (
    .cnt (cnt), .sel_bit (sel_act[0]), .drive_en (drive_en),
    .tap_o (tap_a), .q (out_a)
  );

  out_group #(.GRP(GRP_B), .WIDTH(1)) u_grp_b (
    .cnt (cnt), .sel_bit (sel_act[1]), .drive_en (drive_en),
    .tap_o (tap_b), .q (out_b)
  );

  out_group #(.GRP(GRP_C), .WIDTH(C_OUTS)) u_grp_c (
    .cnt (cnt), .sel_bit (sel_act[2]), .drive_en (drive_en),
    .tap_o (tap_c), .q (out_c)
  );

  out_group #(.GRP(GRP_D), .WIDTH(D_OUTS)) u_grp_d (
    .cnt (cnt), .sel_bit (sel_act[3]), .drive_en (drive_en),
    .tap_o (tap_d), .q (out_d)
  );

  AST_PHASE_ALIGN: assert property (@(posedge src_clk) disable iff (mr_oe)
    ($rose(tap_d) || $rose(tap_c) || $rose(tap_b)) |-> $rose(tap_a))
    else $error("slower tap rose without A"); // R5

  AST_A_FAST_TOGGLE: assert property (@(posedge src_clk) disable iff (mr_oe)
    (!sel_act[0] && !at_wrap) |=> tap_a != $past(tap_a))
    else $error("A /2 missed a toggle"); // R1

endmodule

// File: tb/clk_div_bank_tb_top.sv
`timescale 1ns/1ps
module clk_div_bank_tb_top;

  logic osc_clk = 1'b0;
  logic test_clk = 1'b0;
  logic diff_clk = 1'b0;
  logic ref_sel = 1'b0;
  logic pll_on = 1'b1;
  logic mr_oe = 1'b1;
  logic [3:0] sel = 4'd0;

  wire       out_a, out_b;
  wire [1:0] out_c;
  wire [4:0] out_d;

  pullup pu_a (out_a);
  pullup pu_b (out_b);
  pullup pu_c0 (out_c[0]);
  pullup pu_c1 (out_c[1]);
  pullup pu_d0 (out_d[0]);
  pullup pu_d1 (out_d[1]);
  pullup pu_d2 (out_d[2]);
  pullup pu_d3 (out_d[3]);
  pullup pu_d4 (out_d[4]);

  int checks = 0;
  int errors = 0;

  always #2 osc_clk = ~osc_clk;                 // 250 MHz
  initial begin #0.5;  forever #5 test_clk = ~test_clk; end
  initial begin #0.25; forever #7 diff_clk = ~diff_clk; end

  clk_div_bank dut_i (
    .osc_clk   (osc_clk),
    .test_clk  (test_clk),
    .diff_clk  (diff_clk),
    .ref_sel   (ref_sel),
    .pll_on    (pll_on),
    .mr_oe     (mr_oe),
    .ratio_sel (sel),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_c     (out_c),
    .out_d     (out_d)
  );

  // Reference model: edge count since release, selects captured every 8th edge
  wire src_m = pll_on ? osc_clk : (ref_sel ? test_clk : diff_clk);
  int k;
  logic [3:0] act;

  always @(posedge src_m or posedge mr_oe) begin
    if (mr_oe) begin
      k   <= 0;
      act <= 4'd0;
    end else begin
      if (k % 8 == 0) act <= sel;
      k <= k + 1;
    end
  end

  function automatic logic lvl(int kk, int period);
    if (kk == 0) return 1'b0;
    return ((kk - 1) % period) < (period / 2);
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge src_m) begin
    string mt;
    mt = pll_on ? "R8" : "R7";
    if (mr_oe) begin
      check("R4 outputs undriven", {out_a, out_b, out_c, 1'b1}, 5'b11111);
      check("R4 D undriven", out_d, 5'b11111);
    end else begin
      check($sformatf("R1 R6 R9 %s A", mt), {4'd0, out_a},
            {4'd0, lvl(k, act[0] ? 4 : 2)});
      check($sformatf("R2 R6 R9 %s B", mt), {4'd0, out_b},
            {4'd0, lvl(k, act[1] ? 8 : 4)});
      check($sformatf("R2 R3 R6 %s C", mt), {3'd0, out_c},
            {3'd0, {2{lvl(k, act[2] ? 8 : 4)}}});
      check($sformatf("R2 R3 R6 %s D", mt), out_d,
            {5{lvl(k, act[3] ? 8 : 4)}});
    end
  end

  task automatic wait_osc(int n);
    repeat (n) @(negedge osc_clk);
    #1;
  endtask

  task automatic release_and_check();
    mr_oe = 1'b0;
    #0.2;
    check("R5 low before first edge", {out_a, out_b, out_c, 1'b0}, 5'b00000);
    check("R5 D low before first edge", out_d, 5'b00000);
  endtask

  initial begin
    wait_osc(4);
    check("R4 reset z A/B/C", {out_a, out_b, out_c, 1'b1}, 5'b11111);
    release_and_check();
    for (int code = 0; code < 16; code++) begin
      wait_osc(3);
      sel = code[3:0];
      wait_osc(21);
    end
    // mid-run reset
    mr_oe = 1'b1;
    wait_osc(3);
    check("R4 mid-run z D", out_d, 5'b11111);
    release_and_check();
    wait_osc(40);
    // bypass through test clock
    mr_oe = 1'b1;
    pll_on = 1'b0;
    ref_sel = 1'b1;
    sel = 4'b1010;
    wait_osc(6);
    release_and_check();
    wait_osc(70);
    sel = 4'b0101;
    wait_osc(70);
    // bypass through differential-derived clock
    mr_oe = 1'b1;
    ref_sel = 1'b0;
    sel = 4'b0011;
    wait_osc(6);
    release_and_check();
    wait_osc(90);
    sel = 4'b1100;
    wait_osc(90);
    // oscillator again with ref_sel high: must ignore the reference
    mr_oe = 1'b1;
    pll_on = 1'b1;
    ref_sel = 1'b1;
    wait_osc(4);
    release_and_check();
    wait_osc(40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule